// File: doc/BRIEF.md
# Edge Event Timestamper

This block watches up to eight input levels that have already been conditioned and detects transitions on them. A 2-bit edge-type control picks which transitions count: rising, falling, both or none. For every transition that counts, the block stores the channel, the direction and the value of a free-running cycle counter at that moment. It then pushes this record into an output queue. The consumer side sees one 32-bit record word at a time, with a valid bit beside it, and takes a record on every clock where it asserts ready.

A synchronisation pulse from the surrounding system divides time into frames. Within one frame only a fixed number of records (512 by default) may enter the queue, and any later events in that frame are thrown away. Records are also lost when the queue is full, and when a channel changes again before its earlier event has been moved into the queue. Every such loss sets a sticky error flag, which clears at the next synchronisation pulse.

Top module: `edge_event_stamper`

## Requirements
- R1: After a synchronous reset, `rec_valid` and `loss_err` are low and the timestamp counter restarts at 0 on the first rising clock edge with `rst_n` high.
- R2: `edge_sel` bit 0 enables falling (1 to 0) events and bit 1 enables rising (0 to 1) events. 2'b00 produces no records.
- R3: Input bits at index NUM_CH and above never produce records.
- R4: A record word is {channel index [31:29] (0-based bit index of `lvl_in`), direction [28] (1 = rising), timestamp [27:0]}. The timestamp is the number of clock edges since reset release, counted before the edge that first sees the new level.
- R5: With the queue empty, a record appears on `rec_valid`/`rec_data` after the second rising edge that follows the change of the input level.
- R6: Events on several channels at the same edge are queued one per cycle in ascending channel order, and all of them carry the same timestamp.
- R7: An event on a channel whose previous event has not yet moved into the queue is dropped and sets `loss_err`.
- R8: A record leaves the queue on each edge where `rec_valid` and `out_ready` are both high. While `rec_valid` is high and `out_ready` is low, `rec_data` stays unchanged. `rec_valid` is low when the queue is empty.
- R9: At most FRAME_LIMIT records enter the queue between two sync pulses. Later ones are dropped and set `loss_err`.
- R10: A record that arrives when the queue holds FIFO_DEPTH entries is dropped and sets `loss_err`.
- R11: `loss_err` stays high until an edge where `sync_pulse` is high. That edge clears it, unless a new drop happens on the same edge.
- R12: A sync pulse restarts the per-frame count. A record queued on the sync edge counts toward the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_in | input | 8 | Conditioned input levels, bit i is channel index i |
| edge_sel | input | 2 | Edge-type control: bit 0 falling, bit 1 rising |
| sync_pulse | input | 1 | Frame boundary pulse |
| out_ready | input | 1 | Consumer accepts the presented record |
| rec_data | output | 32 | Record at the head of the queue |
| rec_valid | output | 1 | A record is presented |
| loss_err | output | 1 | Sticky data-loss flag |

## Verification
The hardest state to reach is the frame limit. Getting there takes more than 512 accepted events inside one frame, while the consumer keeps draining so that the queue never fills first. The bench pulses sync, toggles one channel with both edge types enabled on every cycle for 600 cycles with ready held high, and then counts exactly 512 records at the port. A separate run holds ready low to fill the queue. Toggling all enabled channels on every cycle starves the highest channel and forces the per-channel drop.

// File: rtl/eet_pkg.sv
// Shared constants and the record layout of the edge event timestamper.
// Assumes a 32-bit record with a 3-bit channel index and one direction bit.
package eet_pkg;
    localparam int MAX_CH   = 8;
    localparam int CH_IDX_W = 3;
    localparam int REC_W    = 32;
    localparam int TS_W     = REC_W - CH_IDX_W - 1;

    typedef struct packed {
        logic [CH_IDX_W-1:0] ch;
        logic                rising;
        logic [TS_W-1:0]     ts;
    } rec_t;
endpackage

// File: rtl/eet_edge_detect.sv
// Per-channel transition detector. Compares the current level with the level
// registered on the previous edge and qualifies each change with the edge-type
// control. Assumes the inputs are already synchronous. Channels at or above
// NUM_CH are tied off.
module eet_edge_detect
    import eet_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAX_CH-1:0] lvl_in,
    input  logic [1:0]        edge_sel,
    output logic [MAX_CH-1:0] ev_o,
    output logic [MAX_CH-1:0] rising_o
);
    logic [MAX_CH-1:0] prev;

    // Hold the level seen on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl_in;
    end

    for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
        if (c < NUM_CH) begin : g_on
            logic up, down;
            assign up          = lvl_in[c] & ~prev[c];
            assign down        = ~lvl_in[c] & prev[c];
            assign ev_o[c]     = (up & edge_sel[1]) | (down & edge_sel[0]);
            assign rising_o[c] = up;
        end else begin : g_off
            assign ev_o[c]     = 1'b0;
            assign rising_o[c] = 1'b0;
        end
    end

    // R2
    ev_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_o & ~(lvl_in ^ prev)) == '0);
endmodule

// File: rtl/eet_event_slots.sv
// One holding slot per channel. Each slot keeps the direction and timestamp
// of one detected event. Every cycle the lowest-numbered full slot is granted
// and emptied. A new event for a slot that is still full and not granted is
// reported as a drop. Assumes the caller accepts or discards the grant in the
// same cycle.
module eet_event_slots
    import eet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAX_CH-1:0] ev_i,
    input  logic [MAX_CH-1:0] rising_i,
    input  logic [TS_W-1:0]   ts_now,
    output logic              gnt_valid,
    output rec_t              gnt_rec,
    output logic              busy_drop
);
    logic [MAX_CH-1:0] sv;
    logic [MAX_CH-1:0] sdir;
    logic [TS_W-1:0]   sts [MAX_CH];
    logic [MAX_CH-1:0] gnt;
    logic [CH_IDX_W-1:0] gnt_idx;

    // Priority pick of the lowest-numbered full slot.
    always_comb begin
        logic found;
        found   = 1'b0;
        gnt     = '0;
        gnt_idx = '0;
        for (int i = 0; i < MAX_CH; i++) begin
            if (sv[i] && !found) begin
                found   = 1'b1;
                gnt[i]  = 1'b1;
                gnt_idx = CH_IDX_W'(i);
            end
        end
    end

    assign gnt_valid      = |sv;
    assign gnt_rec.ch     = gnt_idx;
    assign gnt_rec.rising = sdir[gnt_idx];
    assign gnt_rec.ts     = sts[gnt_idx];
    assign busy_drop      = |(ev_i & sv & ~gnt);

    // Load slots on new events and empty the granted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv   <= '0;
            sdir <= '0;
            for (int i = 0; i < MAX_CH; i++) sts[i] <= '0;
        end else begin
            for (int i = 0; i < MAX_CH; i++) begin
                if (ev_i[i] && (!sv[i] || gnt[i])) begin
                    sv[i]   <= 1'b1;
                    sdir[i] <= rising_i[i];
                    sts[i]  <= ts_now;
                end else if (gnt[i]) begin
                    sv[i] <= 1'b0;
                end
            end
        end
    end

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R6
    grant_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !ev_i[gnt_idx]) |=> !sv[$past(gnt_idx)]);
endmodule

// File: rtl/eet_rec_fifo.sv
// Synchronous record queue with first-word presentation: the head entry is
// visible whenever the queue is not empty. Assumes DEPTH is a power of two and
// that the writer never pushes when full and the reader never pops when empty.
module eet_rec_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;

    assign empty_o   = (cnt == '0);
    assign full_o    = (cnt == (AW+1)'(DEPTH));
    assign rd_data_o = mem[rd_ptr];

    // Storage write, no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(wr_en) - (AW+1)'(rd_en);
        end
    end

    // R10
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full_o);
    // R8
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty_o);
    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_o && !rd_en) |=> $stable(rd_data_o));
endmodule

// File: rtl/edge_event_stamper.sv
// Top level of the edge event timestamper. Runs the free-running timestamp,
// detects qualified edges, moves slot records into the queue under the
// per-frame limit and the queue capacity, and keeps the sticky loss flag.
// Assumes sync_pulse and out_ready are synchronous to clk.
module edge_event_stamper
    import eet_pkg::*;
#(
    parameter int NUM_CH        = 8,
    parameter int FRAME_LIMIT   = 512,
    parameter int FIFO_DEPTH    = 32,
    parameter bit HAS_LOSS_FLAG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       lvl_in,
    input  logic [1:0]       edge_sel,
    input  logic             sync_pulse,
    input  logic             out_ready,
    output logic [REC_W-1:0] rec_data,
    output logic             rec_valid,
    output logic             loss_err
);
    localparam int CNT_W = $clog2(FRAME_LIMIT + 1);

    logic [TS_W-1:0]   tick;
    logic [MAX_CH-1:0] ev, rising;
    logic              gnt_valid, busy_drop;
    rec_t              gnt_rec;
    logic              q_empty, q_full, q_wr, q_rd;
    logic [CNT_W-1:0]  frame_cnt, cnt_eff;
    logic              accept, drop_now, loss_q;

    // Free-running timestamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= '0;
        else        tick <= tick + 1'b1;
    end

    eet_edge_detect #(.NUM_CH(NUM_CH)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (lvl_in),
        .edge_sel (edge_sel),
        .ev_o     (ev),
        .rising_o (rising)
    );

    eet_event_slots u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev),
        .rising_i  (rising),
        .ts_now    (tick),
        .gnt_valid (gnt_valid),
        .gnt_rec   (gnt_rec),
        .busy_drop (busy_drop)
    );

    // Admission: a sync edge opens a new frame before this cycle's record counts.
    always_comb begin
        cnt_eff  = sync_pulse ? '0 : frame_cnt;
        accept   = gnt_valid && !q_full && (cnt_eff < CNT_W'(FRAME_LIMIT));
        drop_now = busy_drop || (gnt_valid && !accept);
    end

    assign q_wr = accept;
    assign q_rd = out_ready && !q_empty;

    eet_rec_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (q_wr),
        .wr_data   (gnt_rec),
        .rd_en     (q_rd),
        .rd_data_o (rec_data),
        .empty_o   (q_empty),
        .full_o    (q_full)
    );

    assign rec_valid = !q_empty;

    // Per-frame admission counter.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_cnt <= '0;
        else        frame_cnt <= cnt_eff + CNT_W'(accept);
    end

    // Sticky loss flag: a drop sets it, and a sync edge without a drop clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)          loss_q <= 1'b0;
        else if (drop_now)   loss_q <= 1'b1;
        else if (sync_pulse) loss_q <= 1'b0;
    end

    if (HAS_LOSS_FLAG) begin : g_loss
        assign loss_err = loss_q;
    end else begin : g_noloss
        assign loss_err = 1'b0;
    end

    // R9
    frame_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CNT_W'(FRAME_LIMIT));
    // R11
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && !drop_now) |=> !loss_q);
    // R7
    loss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_q) |-> $past(drop_now));
    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !out_ready) |=> rec_valid);
endmodule

// File: tb/tb_edge_event_stamper.sv
module tb_edge_event_stamper;
    localparam int B_CH    = 6;
    localparam int B_LIMIT = 512;
    localparam int B_DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  lvl_in;
    logic [1:0]  edge_sel;
    logic        sync_pulse;
    logic        out_ready;
    logic [31:0] rec_data;
    logic        rec_valid;
    logic        loss_err;

    always #5 clk = ~clk;

    edge_event_stamper #(.NUM_CH(B_CH), .FRAME_LIMIT(B_LIMIT),
                         .FIFO_DEPTH(B_DEPTH), .HAS_LOSS_FLAG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .edge_sel(edge_sel),
        .sync_pulse(sync_pulse), .out_ready(out_ready), .rec_data(rec_data),
        .rec_valid(rec_valid), .loss_err(loss_err));

    int          checks = 0;
    int          fails  = 0;
    string       phase_req = "R1";
    bit          cmp_on = 1'b0;
    int unsigned cyc = 0;
    int          pops = 0;
    bit [31:0]   got[$];
    bit          done = 1'b0;

    // Behavioural reference state.
    bit [7:0]    m_prev;
    bit          m_sv[8];
    bit          m_sdir[8];
    int unsigned m_sts[8];
    bit [31:0]   m_q[$];
    int          m_cnt;
    bit          m_loss;
    int unsigned m_tick;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        if (rst_n && rec_valid && out_ready) begin
            pops <= pops + 1;
            got.push_back(rec_data);
        end
    end

    always @(posedge clk) begin : model
        int  serve;
        bit  lost;
        bit  full;
        int  ceff;
        bit  r, f;
        if (!rst_n) begin
            m_prev = '0; m_q.delete(); m_cnt = 0; m_loss = 0; m_tick = 0;
            for (int i = 0; i < 8; i++) begin m_sv[i] = 0; m_sdir[i] = 0; m_sts[i] = 0; end
        end else begin
            full = (m_q.size() >= B_DEPTH);
            if (m_q.size() > 0 && out_ready) void'(m_q.pop_front());
            serve = -1;
            for (int i = 0; i < 8; i++) if (m_sv[i] && serve < 0) serve = i;
            lost = 0;
            ceff = sync_pulse ? 0 : m_cnt;
            if (serve >= 0) begin
                if (!full && ceff < B_LIMIT) begin
                    m_q.push_back({3'(serve), m_sdir[serve], 28'(m_sts[serve])});
                    ceff++;
                end else lost = 1;
                m_sv[serve] = 0;
            end
            for (int c = 0; c < B_CH; c++) begin
                r = lvl_in[c] && !m_prev[c];
                f = !lvl_in[c] && m_prev[c];
                if ((r && edge_sel[1]) || (f && edge_sel[0])) begin
                    if (m_sv[c]) lost = 1;
                    else begin m_sv[c] = 1; m_sdir[c] = r; m_sts[c] = m_tick; end
                end
            end
            m_cnt  = ceff;
            m_loss = lost ? 1'b1 : (sync_pulse ? 1'b0 : m_loss);
            m_prev = lvl_in;
            m_tick++;
        end
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            checks++;
            if (rec_valid !== (m_q.size() > 0) || loss_err !== m_loss ||
                (m_q.size() > 0 && rec_data !== m_q[0])) begin
                fails++;
                $display("FAIL %s cycle %0d: valid=%0b/%0b loss=%0b/%0b data=%h/%h",
                         phase_req, cyc, rec_valid, (m_q.size() > 0), loss_err, m_loss,
                         rec_data, (m_q.size() > 0) ? m_q[0] : 32'h0);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin : main
        int unsigned exp_ts;
        bit [31:0]   held;
        rst_n = 0; lvl_in = 0; edge_sel = 2'b11; sync_pulse = 0; out_ready = 1;
        nclk(3);
        // R1: reset state
        chk(rec_valid == 0, "R1 valid", rec_valid, 0);
        chk(loss_err == 0, "R1 loss", loss_err, 0);
        rst_n = 1; cmp_on = 1;

        // R4 / R5: single rising event on channel 0
        phase_req = "R4";
        nclk(2);
        edge_sel = 2'b10; lvl_in[0] = 1; exp_ts = cyc;
        nclk(1);
        chk(rec_valid == 0, "R5 early", rec_valid, 0);
        nclk(1);
        chk(rec_valid == 1, "R5 latency", rec_valid, 1);
        chk(rec_data == {3'd0, 1'b1, 28'(exp_ts)}, "R4 record", rec_data, {3'd0, 1'b1, 28'(exp_ts)});

        // R2: falling ignored with rising only, rising ignored with falling only
        phase_req = "R2";
        nclk(1); lvl_in[0] = 0;
        nclk(4);
        chk(rec_valid == 0, "R2 fall masked", rec_valid, 0);
        edge_sel = 2'b01; lvl_in[1] = 1;
        nclk(4);
        chk(rec_valid == 0, "R2 rise masked", rec_valid, 0);
        lvl_in[1] = 0; exp_ts = cyc;
        nclk(2);
        chk(rec_data == {3'd1, 1'b0, 28'(exp_ts)}, "R2 fall record", rec_data, {3'd1, 1'b0, 28'(exp_ts)});
        nclk(1); edge_sel = 2'b00; lvl_in[2] = 1;
        nclk(2); lvl_in[2] = 0;
        nclk(3);
        chk(rec_valid == 0, "R2 none", rec_valid, 0);

        // R3: channels above the count are ignored
        phase_req = "R3";
        edge_sel = 2'b11;
        for (int k = 0; k < 6; k++) begin
            lvl_in[7:6] = ~lvl_in[7:6];
            nclk(1);
            chk(rec_valid == 0, "R3 high channels", rec_valid, 0);
        end
        nclk(3);
        chk(rec_valid == 0, "R3 settle", rec_valid, 0);

        // R6: simultaneous edges
        phase_req = "R6";
        out_ready = 0; lvl_in[5:0] = 6'h3F; exp_ts = cyc;
        nclk(10);
        got.delete(); out_ready = 1;
        nclk(10);
        chk(got.size() == 6, "R6 count", got.size(), 6);
        for (int i = 0; i < 6 && i < got.size(); i++)
            chk(got[i] == {3'(i), 1'b1, 28'(exp_ts)}, "R6 order/ts", got[i], {3'(i), 1'b1, 28'(exp_ts)});

        // R7: slot overrun on the starved channel
        phase_req = "R7";
        for (int k = 0; k < 6; k++) begin lvl_in[5:0] = ~lvl_in[5:0]; nclk(1); end
        nclk(20);
        chk(loss_err == 1, "R7 loss", loss_err, 1);

        // R11: sticky until sync
        phase_req = "R11";
        nclk(5);
        chk(loss_err == 1, "R11 sticky", loss_err, 1);
        sync_pulse = 1; nclk(1); sync_pulse = 0;
        chk(loss_err == 0, "R11 cleared", loss_err, 0);

        // R10 / R8: queue full with ready low
        phase_req = "R10";
        out_ready = 0;
        for (int k = 0; k < 40; k++) begin lvl_in[0] = ~lvl_in[0]; nclk(1); end
        nclk(4);
        chk(loss_err == 1, "R10 loss", loss_err, 1);
        held = rec_data;
        nclk(3);
        chk(rec_valid == 1 && rec_data == held, "R8 hold", rec_data, held);
        pops = 0; out_ready = 1;
        nclk(40);
        chk(pops == B_DEPTH, "R10 kept", pops, B_DEPTH);
        chk(rec_valid == 0, "R8 empty", rec_valid, 0);

        // R9: frame limit
        phase_req = "R9";
        sync_pulse = 1; pops = 0; nclk(1); sync_pulse = 0;
        for (int k = 0; k < 600; k++) begin lvl_in[0] = ~lvl_in[0]; nclk(1); end
        nclk(10);
        chk(pops == B_LIMIT, "R9 admitted", pops, B_LIMIT);
        chk(loss_err == 1, "R9 loss", loss_err, 1);

        // R12: new frame restarts the count
        phase_req = "R12";
        sync_pulse = 1; pops = 0; nclk(1); sync_pulse = 0;
        for (int k = 0; k < 5; k++) begin lvl_in[0] = ~lvl_in[0]; nclk(1); end
        nclk(10);
        chk(pops == 5, "R12 count", pops, 5);
        chk(loss_err == 0, "R12 loss", loss_err, 0);

        // Mixed random traffic (R8, R11, R12 interplay)
        phase_req = "R8/R12 random";
        for (int k = 0; k < 3000; k++) begin
            lvl_in     = 8'($urandom);
            edge_sel   = 2'($urandom);
            out_ready  = ($urandom % 4) != 0;
            sync_pulse = ($urandom % 150) == 0;
            nclk(1);
        end
        sync_pulse = 0; out_ready = 1;
        nclk(50);
        chk(rec_valid == 0, "R8 final drain", rec_valid, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule